// File: doc/BRIEF.md
# TLB-Backed Address Translation Unit

This block maps 14-bit virtual byte addresses to 12-bit physical byte addresses for a small byte-addressable memory. Each request carries a virtual address and an access kind, read or write. The page offset is the low 6 bits (64-byte pages), and it passes through unchanged. The 8-bit virtual page number is replaced by a 6-bit physical page number.

A 16-entry translation buffer is checked first. It has 4 sets of 4 ways, and each entry keeps the tag, the physical page and the two access permissions. On a hit, the answer comes back in the next cycle. On a miss, the unit fetches one 16-bit page-table word through a read port with one cycle of latency, at the table base plus the virtual page number. It checks that word and then answers. The word is written into the buffer only when the translation succeeds.

Each answer is one of three outcomes: a physical address, a page fault (the page is not resident) or a protection fault (the access kind is not permitted). A flush input invalidates the whole buffer.

Top module: `vm_xlate_unit`

## Requirements
- R1: While in reset and right after it, `req_ready` is 1, `rsp_valid` is 0 and `pt_rd_en` is 0.
- R2: A successful translation returns `rsp_paddr = {ppn, req_vaddr[5:0]}`, with status 2'b00.
- R3: A request accepted on a buffer hit makes no table read, and its response is valid in the cycle after acceptance.
- R4: A request accepted on a miss raises `pt_rd_en` in the acceptance cycle, with `pt_rd_addr = (pt_base + vpn) mod 2^PT_AW`. `req_ready` and `rsp_valid` are low in the following cycle, and the response is valid in the cycle after that.
- R5: A table word has bit 15 = valid, bit 14 = read allowed, bit 13 = write allowed, bits 12:6 ignored and bits 5:0 = physical page. A fetched word with bit 15 = 0 answers status 2'b01 (page fault).
- R6: A read needs the read bit and a write needs the write bit, whether the permissions come from the buffer or from the table. Otherwise the status is 2'b10 (protection fault). Both fault statuses return a physical address of 0.
- R7: A faulting walk never fills the buffer, so a repeated access to the same page walks again.
- R8: The set is vpn[1:0] and the tag is vpn[7:2]. A fill uses the lowest-numbered invalid way of its set. If the set is full, the fill uses that set's round-robin pointer, which starts at 0 and advances only on such replacements. Other sets are unaffected.
- R9: A flush invalidates every entry in one cycle, so any request accepted afterwards misses. A flush in the same cycle as a fill cancels that fill.
- R10: Every accepted request produces exactly one response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | PT_AW (10) | Word address of the page table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W (14) | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present (single cycle) |
| rsp_paddr | output | PA_W (12) | Physical byte address, 0 on fault |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_addr | output | PT_AW (10) | Page-table word address |
| pt_rd_data | input | PTE_W (16) | Table word, valid the cycle after the strobe |

## Verification
A corrupted buffer entry shows up at the port in one of two ways. A stale tag or a wrong victim choice changes hit versus miss, and `pt_rd_en` then appears or goes missing in the acceptance cycle. A wrong stored page or permission shows up in `rsp_paddr` or `rsp_status` one cycle after a hit. The bench keeps its own behavioural copy of buffer contents and replacement pointers. It therefore notices a wrong eviction at the first later access to the evicted or kept page. A fault that leaked into the buffer is caught at the next repeated access, because that access answers without a table read.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  typedef enum logic [1:0] {
    XS_OK   = 2'b00,
    XS_PAGE = 2'b01,
    XS_PROT = 2'b10
  } xl_status_e;

  localparam int PTE_V_BIT = 15;
  localparam int PTE_R_BIT = 14;
  localparam int PTE_W_BIT = 13;

  function automatic logic access_ok(input logic can_rd, input logic can_wr, input logic is_wr);
    return is_wr ? can_wr : can_rd;
  endfunction
endpackage

// File: rtl/vmx_tlb.sv
module vmx_tlb #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int N     = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_rd,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr
);
  logic [N-1:0]       vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q [N];
  logic [PPN_W-1:0]   ppn_q [N];
  logic [N-1:0]       rd_q, wr_q;
  logic [WAY_W-1:0]   rr_q [SETS];
  logic [WAY_W-1:0]   rr_d [SETS];
  logic [WAYS-1:0]    hit_vec;
  logic [WAY_W-1:0]   vic_way;
  logic               have_free;
  logic               fill_go;
  logic [SET_W+WAY_W-1:0] fill_idx;

  // one comparator per way of the addressed set
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[{lk_set, WAY_W'(g)}] &&
                        (tag_q[{lk_set, WAY_W'(g)}] == lk_tag);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_ppn = '0;
    lk_rd  = 1'b0;
    lk_wr  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        lk_ppn = lk_ppn | ppn_q[{lk_set, WAY_W'(w)}];
        lk_rd  = lk_rd  | rd_q[{lk_set, WAY_W'(w)}];
        lk_wr  = lk_wr  | wr_q[{lk_set, WAY_W'(w)}];
      end
    end
  end

  // victim: lowest invalid way, else the set's rotating pointer
  always_comb begin
    have_free = 1'b0;
    vic_way   = rr_q[fill_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[{fill_set, WAY_W'(w)}]) begin
        have_free = 1'b1;
        vic_way   = WAY_W'(w);
      end
    end
  end

  assign fill_go  = fill_en && !flush;
  assign fill_idx = {fill_set, vic_way};

  always_comb begin
    vld_d = vld_q;
    for (int s = 0; s < SETS; s++) rr_d[s] = rr_q[s];
    if (flush) begin
      vld_d = '0;
    end else if (fill_go) begin
      vld_d[fill_idx] = 1'b1;
      if (!have_free) rr_d[fill_set] = rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int s = 0; s < SETS; s++) rr_q[s] <= rr_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_idx] <= fill_tag;
      ppn_q[fill_idx] <= fill_ppn;
      rd_q[fill_idx]  <= fill_rd;
      wr_q[fill_idx]  <= fill_wr;
    end
  end

  assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  assert_fill_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && have_free) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));
  assert_fill_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !have_free) |=> ($countones(vld_q) == $past($countones(vld_q))));
endmodule

// File: rtl/vmx_walk.sv
module vmx_walk
  import vmx_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int PT_AW = 10,
  parameter int PTE_W = 16,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [PT_AW-1:0] pt_base,
  input  logic             lk_hit,
  input  logic [PPN_W-1:0] lk_ppn,
  input  logic             lk_rd,
  input  logic             lk_wr,
  output logic             pt_rd_en,
  output logic [PT_AW-1:0] pt_rd_addr,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_rd,
  output logic             fill_wr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_status
);
  typedef enum logic {W_IDLE, W_WAIT} wst_e;

  wst_e             st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             cap_en;
  logic             rv_q, rv_d;
  xl_status_e       rs_q, rs_d;
  logic [PA_W-1:0]  rp_q, rp_d;
  logic             pte_v, pte_r, pte_w;

  assign pte_v = pt_rd_data[PTE_V_BIT];
  assign pte_r = pt_rd_data[PTE_R_BIT];
  assign pte_w = pt_rd_data[PTE_W_BIT];

  assign pt_rd_addr = pt_base + PT_AW'(req_vaddr[VA_W-1:OFF_W]);
  assign fill_vpn   = vpn_q;
  assign fill_ppn   = pt_rd_data[PPN_W-1:0];
  assign fill_rd    = pte_r;
  assign fill_wr    = pte_w;

  always_comb begin
    st_d      = st_q;
    req_ready = (st_q == W_IDLE);
    pt_rd_en  = 1'b0;
    cap_en    = 1'b0;
    fill_en   = 1'b0;
    rv_d      = 1'b0;
    rs_d      = XS_OK;
    rp_d      = '0;
    case (st_q)
      W_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          if (lk_hit) begin
            rv_d = 1'b1;
            if (access_ok(lk_rd, lk_wr, req_write)) rp_d = {lk_ppn, req_vaddr[OFF_W-1:0]};
            else                                     rs_d = XS_PROT;
          end else begin
            pt_rd_en = 1'b1;
            st_d     = W_WAIT;
          end
        end
      end
      default: begin
        rv_d = 1'b1;
        st_d = W_IDLE;
        if (!pte_v) begin
          rs_d = XS_PAGE;
        end else if (!access_ok(pte_r, pte_w, wr_q)) begin
          rs_d = XS_PROT;
        end else begin
          fill_en = 1'b1;
          rp_d    = {pt_rd_data[PPN_W-1:0], off_q};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE;
      rv_q <= 1'b0;
      rs_q <= XS_OK;
      rp_q <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      rs_q <= rs_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      vpn_q <= req_vaddr[VA_W-1:OFF_W];
      off_q <= req_vaddr[OFF_W-1:0];
      wr_q  <= req_write;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_paddr  = rp_q;
  assign rsp_status = rs_q;

  assert_walk_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> (!rsp_valid && !req_ready));
  assert_walk_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> ##1 rsp_valid);
  assert_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> rsp_valid);
  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != XS_OK) |-> (rsp_paddr == '0));
  assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready && lk_hit) || $past(st_q == W_WAIT)));
  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'b11));
endmodule

// File: rtl/vm_xlate_unit.sv
module vm_xlate_unit #(
  parameter int VA_W       = 14,
  parameter int PA_W       = 12,
  parameter int PAGE_BYTES = 64,
  parameter int TLB_SETS   = 4,
  parameter int TLB_WAYS   = 4,
  parameter int PT_AW      = 10,
  parameter int PTE_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PT_AW-1:0] pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_status,
  output logic             pt_rd_en,
  output logic [PT_AW-1:0] pt_rd_addr,
  input  logic [PTE_W-1:0] pt_rd_data
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SET_W = $clog2(TLB_SETS);
  localparam int TAG_W = VPN_W - SET_W;

  logic             lk_hit, lk_rd, lk_wr;
  logic [PPN_W-1:0] lk_ppn;
  logic             fill_en, fill_rd, fill_wr;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;

  vmx_tlb #(.SETS(TLB_SETS), .WAYS(TLB_WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_set   (req_vaddr[OFF_W+SET_W-1:OFF_W]),
    .lk_tag   (req_vaddr[VA_W-1:OFF_W+SET_W]),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr),
    .fill_en  (fill_en),
    .fill_set (fill_vpn[SET_W-1:0]),
    .fill_tag (fill_vpn[VPN_W-1:SET_W]),
    .fill_ppn (fill_ppn),
    .fill_rd  (fill_rd),
    .fill_wr  (fill_wr)
  );

  vmx_walk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PT_AW(PT_AW), .PTE_W(PTE_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .pt_base    (pt_base),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_rd      (lk_rd),
    .lk_wr      (lk_wr),
    .pt_rd_en   (pt_rd_en),
    .pt_rd_addr (pt_rd_addr),
    .pt_rd_data (pt_rd_data),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_rd    (fill_rd),
    .fill_wr    (fill_wr),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_status (rsp_status)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && req_ready));
endmodule

// File: tb/vm_xlate_unit_tb.sv
`timescale 1ns/1ps
module vm_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [9:0]  pt_base = 10'h100;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        pt_rd_en;
  logic [9:0]  pt_rd_addr;
  logic [15:0] pt_q = '0;

  int n_cmp = 0, n_bad = 0, n_req = 0, n_rsp = 0;

  // behavioural model of buffer contents
  bit       mv [16];
  int       mtag [16];
  int       mppn [16];
  bit       mr [16];
  bit       mw [16];
  int       mrr [4];

  always #4 clk = ~clk;

  vm_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_status(rsp_status), .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr),
    .pt_rd_data(pt_q)
  );

  // page table word for a table address: valid unless low3==7, read unless low3==6, write when even
  function automatic logic [15:0] pte_gen(input logic [9:0] a);
    logic [5:0] p;
    p = a[5:0] * 6'd5 + 6'd3;
    return {(a[2:0] != 3'b111), (a[2:0] != 3'b110), ~a[0], 7'h55, p};
  endfunction

  always @(posedge clk) if (pt_rd_en) pt_q <= pte_gen(pt_rd_addr);

  always @(negedge clk) if (rst_n && rsp_valid) n_rsp++;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 16; i++) mv[i] = 1'b0;
  endtask

  task automatic xlate(input int vpn, input int off, input bit wr, input bit flush_mid, input string tag);
    int set, tg, hw, way, exp_st, exp_pa;
    bit hit, ok;
    logic [15:0] pte;
    set = vpn % 4; tg = vpn / 4; hit = 1'b0; hw = 0;
    for (int w = 0; w < 4; w++)
      if (mv[set*4+w] && mtag[set*4+w] == tg) begin hit = 1'b1; hw = set*4+w; end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 14'((vpn << 6) | off); req_write = wr;
    #1;
    chk_eq({tag, " R1 ready when idle"}, req_ready, 1);
    chk_eq({tag, " R3 R4 walk strobe"}, pt_rd_en, !hit);
    if (!hit) chk_eq({tag, " R4 walk address"}, pt_rd_addr, (pt_base + vpn) % 1024);
    @(negedge clk);
    req_valid = 1'b0;
    n_req++;
    if (hit) begin
      ok = wr ? mw[hw] : mr[hw];
      exp_st = ok ? 0 : 2;
      exp_pa = ok ? ((mppn[hw] << 6) | off) : 0;
      chk_eq({tag, " R3 hit response"}, rsp_valid, 1);
    end else begin
      chk_eq({tag, " R4 wait no response"}, rsp_valid, 0);
      chk_eq({tag, " R4 wait not ready"}, req_ready, 0);
      if (flush_mid) flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      pte = pte_gen(10'(pt_base + vpn));
      if (!pte[15]) begin exp_st = 1; exp_pa = 0; end
      else if (!(wr ? pte[13] : pte[14])) begin exp_st = 2; exp_pa = 0; end
      else begin
        exp_st = 0; exp_pa = (int'(pte[5:0]) << 6) | off;
        if (!flush_mid) begin
          way = -1;
          for (int w = 0; w < 4; w++) if (!mv[set*4+w] && way < 0) way = w;
          if (way < 0) begin way = mrr[set]; mrr[set] = (mrr[set] + 1) % 4; end
          mv[set*4+way] = 1'b1; mtag[set*4+way] = tg; mppn[set*4+way] = int'(pte[5:0]);
          mr[set*4+way] = pte[14]; mw[set*4+way] = pte[13];
        end
      end
      if (flush_mid) for (int i = 0; i < 16; i++) mv[i] = 1'b0;
      chk_eq({tag, " R4 walk response"}, rsp_valid, 1);
    end
    chk_eq({tag, " R5 R6 status"}, rsp_status, exp_st);
    chk_eq({tag, " R2 physical address"}, rsp_paddr, exp_pa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mv[i] = 1'b0;
    for (int s = 0; s < 4; s++) mrr[s] = 0;
    repeat (2) @(negedge clk);
    chk_eq("R1 ready in reset", req_ready, 1);
    chk_eq("R1 no response in reset", rsp_valid, 0);
    chk_eq("R1 no walk in reset", pt_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 no response after reset", rsp_valid, 0);
    chk_eq("R1 no walk after reset", pt_rd_en, 0);

    xlate(8'h00, 6'h15, 0, 0, "R4 first touch");
    xlate(8'h00, 6'h3F, 1, 0, "R2 hit top offset");
    xlate(8'h07, 6'h01, 0, 0, "R5 page fault");
    xlate(8'h07, 6'h01, 0, 0, "R7 fault rewalks");
    xlate(8'h06, 6'h00, 0, 0, "R6 read not allowed");
    xlate(8'h06, 6'h00, 0, 0, "R7 prot rewalks");
    xlate(8'h06, 6'h22, 1, 0, "R6 write allowed");
    xlate(8'h06, 6'h22, 0, 0, "R6 hit read denied");
    xlate(8'h01, 6'h10, 1, 0, "R6 write denied");
    xlate(8'h01, 6'h10, 0, 0, "R7 read after prot");
    xlate(8'h01, 6'h11, 1, 0, "R6 hit write denied");
    // fill set 0 then replace
    xlate(8'h04, 6'h01, 0, 0, "R8 fill way1");
    xlate(8'h08, 6'h02, 0, 0, "R8 fill way2");
    xlate(8'h0C, 6'h03, 0, 0, "R8 fill way3");
    xlate(8'h10, 6'h04, 0, 0, "R8 evict way0");
    xlate(8'h04, 6'h05, 0, 0, "R8 kept entry");
    xlate(8'h00, 6'h06, 0, 0, "R8 evicted entry");
    xlate(8'h08, 6'h07, 0, 0, "R8 kept after second");
    xlate(8'h04, 6'h08, 0, 0, "R8 round robin next");
    xlate(8'h0C, 6'h09, 0, 0, "R8 still present");
    xlate(8'h01, 6'h0A, 0, 0, "R8 other set intact");
    do_flush();
    xlate(8'h01, 6'h0B, 0, 0, "R9 miss after flush");
    xlate(8'h0C, 6'h0C, 0, 0, "R9 second miss");
    xlate(8'h05, 6'h0D, 0, 1, "R9 flush cancels fill");
    xlate(8'h05, 6'h0D, 0, 0, "R9 cancelled fill misses");
    xlate(8'h0C, 6'h0E, 0, 0, "R9 flush cleared others");
    pt_base = 10'h3F0;
    do_flush();
    xlate(8'h20, 6'h1F, 0, 0, "R4 base wraps");
    xlate(8'hFF, 6'h3F, 0, 0, "R4 top page");
    for (int i = 0; i < 40; i++)
      xlate((i * 37 + 11) % 256, (i * 13) % 64, i[0], 0, "R8 mixed");
    for (int i = 0; i < 20; i++)
      xlate((i * 4) % 32, i % 64, 0, 0, "R8 set pressure");
    repeat (2) @(negedge clk);
    chk_eq("R10 one response per request", n_rsp, n_req);
    summary();
    $finish;
  end
endmodule